// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the 32-bit datapath of a small processor that executes each instruction over several clock cycles. It runs a load-store subset: register add, OR with an immediate, load word, store word, branch on equal and jump. One ALU is shared by the PC increment, the branch target calculation and the arithmetic. One memory holds both the program and the data. Registers between the steps hold each partial result. These are the program counter, an instruction register, two operand registers, an ALU result register and a memory data register. A 32-entry register file has two read ports and one write port.

The block has no sequencer. Every select and write enable is an input, and an external controller (here the testbench) drives them cycle by cycle. A typical sequence is fetch, decode, execute, then memory access or write-back. While the controller is idle, a separate fill port loads the program and the initial data into the shared memory.

Top module: `mdp_datapath`

## Requirements
- R1: The instruction register loads the memory word at the current memory address on a clock edge with `ir_wr`=1. It holds its value when `ir_wr`=0.
- R2: The memory byte address is the PC when `iord`=0 and the ALU result register when `iord`=1. Bits [MEM_AW+1:2] of that address select the word.
- R3: On every clock, operand register A loads register-file entry IR[25:21] and operand register B loads entry IR[20:16]. Both use the register values from before that edge.
- R4: The first ALU operand is the PC when `alu_src_a`=0 and A when it is 1. The second operand is chosen by `alu_src_b`: 0 gives B, 1 gives the constant 4, 2 gives the extended IR[15:0], and 3 gives the extended immediate shifted left by two.
- R5: `alu_op` selects the ALU function: 0 add, 1 subtract (first minus second), 2 bitwise OR, 3 bitwise AND. The ALU result register captures the result on every clock. `alu_zero` is 1 exactly when the current result is zero.
- R6: The immediate is sign-extended when `ext_op`=1 and zero-extended when `ext_op`=0.
- R7: `pc_src` selects the next PC: 0 gives the live ALU result, 1 gives the ALU result register, and 2 gives {PC[31:28], IR[25:0], 2'b00}. Code 3 behaves like 0.
- R8: The PC loads on an edge where `pc_wr`=1, or where `pc_wr_cond`=1 and `alu_zero`=1. Otherwise it holds its value.
- R9: With `reg_wr`=1, the register file writes the entry selected by `reg_dst` (0: IR[20:16], 1: IR[15:11]). The data is chosen by `mem_to_reg` (0: ALU result register, 1: memory data register). Entry 0 always reads as zero, and writes to entry 0 have no effect.
- R10: With `mem_wr`=1, the word in B is written to the addressed memory word on the clock edge. The memory data register captures the addressed word on every clock.
- R11: With `fill_we`=1, `fill_data` is written to word `fill_addr`. This happens in reset too, and the fill write wins over a `mem_wr` write to the same word in the same cycle.
- R12: Synchronous active-high reset clears the PC, IR, A, B, ALU result register, memory data register and all register-file entries to zero. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load when the ALU result is zero |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_wr | input | 1 | Store B into memory |
| ir_wr | input | 1 | Instruction register load |
| reg_dst | input | 1 | Write index select: 0 IR[20:16], 1 IR[15:11] |
| mem_to_reg | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| reg_wr | input | 1 | Register file write enable |
| ext_op | input | 1 | 1 sign extension, 0 zero extension |
| alu_src_a | input | 1 | First ALU operand: 0 PC, 1 A |
| alu_src_b | input | 2 | Second ALU operand select |
| alu_op | input | 2 | ALU function |
| pc_src | input | 2 | Next-PC select |
| fill_we | input | 1 | Memory fill write enable |
| fill_addr | input | MEM_AW | Memory fill word index |
| fill_data | input | 32 | Memory fill data |
| pc_q | output | 32 | Program counter |
| ir_q | output | 32 | Instruction register |
| a_q | output | 32 | Operand register A |
| b_q | output | 32 | Operand register B |
| alu_out_q | output | 32 | ALU result register |
| mdr_q | output | 32 | Memory data register |
| alu_zero | output | 1 | Live ALU zero flag |

## Verification
The bound checker checks several rules on every cycle:
- the instruction register and the PC hold when not enabled, and the PC holds on an untaken conditional load;
- the jump and held-target PC sources give the right value;
- the zero flag agrees with the value captured in the ALU result register;
- register index zero reads as zero;
- reset clears the state.

Other behaviour only shows up through the bench's instruction sequences, which a behavioural model follows on every clock. This covers sign versus zero extension, operand selection, memory reuse for fetch and data, the load and store round trip, writes aimed at entry zero being dropped, and fill-port priority.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    localparam int W       = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2,
        ALU_AND = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'd0,
        SRCB_FOUR = 2'd1,
        SRCB_IMM  = 2'd2,
        SRCB_BOFF = 2'd3
    } srcb_e;

    typedef enum logic [1:0] {
        PCSEL_ALU  = 2'd0,
        PCSEL_HELD = 2'd1,
        PCSEL_JUMP = 2'd2,
        PCSEL_RSVD = 2'd3
    } pcsel_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [IMM_W-1:0]  imm;
        logic [TGT_W-1:0]  tgt;
    } fields_t;

    function automatic fields_t split_fields(input logic [W-1:0] ir);
        fields_t f;
        f.rs  = ir[25:21];
        f.rt  = ir[20:16];
        f.rd  = ir[15:11];
        f.imm = ir[IMM_W-1:0];
        f.tgt = ir[TGT_W-1:0];
        return f;
    endfunction

    function automatic logic [W-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                               input logic sign_mode);
        return sign_mode ? {{(W-IMM_W){imm[IMM_W-1]}}, imm}
                         : {{(W-IMM_W){1'b0}}, imm};
    endfunction

    function automatic logic [W-1:0] jump_dest(input logic [W-1:0] pc,
                                               input logic [TGT_W-1:0] tgt);
        return {pc[W-1:TGT_W+2], tgt, 2'b00};
    endfunction

endpackage

// File: rtl/mdp_alu.sv
module mdp_alu
    import mdp_pkg::*;
(
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_op_e      op,
    output logic [W-1:0] result,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: result = op_a + op_b;
            ALU_SUB: result = op_a - op_b;
            ALU_OR:  result = op_a | op_b;
            ALU_AND: result = op_a & op_b;
            default: result = op_a + op_b;
        endcase
    end

    assign zero = (result == '0);

endmodule

// File: rtl/mdp_regfile.sv
module mdp_regfile
    import mdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] rd_idx_a,
    input  logic [RIDX_W-1:0] rd_idx_b,
    output logic [W-1:0]      rd_val_a,
    output logic [W-1:0]      rd_val_b,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [W-1:0]      wr_val
);

    logic [W-1:0] regs [NREG];

    // Entry 0 is never stored: its reads are forced to zero.
    assign rd_val_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
    assign rd_val_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            regs[wr_idx] <= wr_val;
        end
    end

endmodule

// File: rtl/mdp_memory.sv
module mdp_memory
    import mdp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [W-1:0]  fill_data
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] words [DEPTH];

    // Asynchronous read path serves fetch and data access alike.
    assign rdata = words[addr];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            words[fill_addr] <= fill_data;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

endmodule

// File: rtl/mdp_datapath.sv
module mdp_datapath
    import mdp_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_wr,
    input  logic              pc_wr_cond,
    input  logic              iord,
    input  logic              mem_wr,
    input  logic              ir_wr,
    input  logic              reg_dst,
    input  logic              mem_to_reg,
    input  logic              reg_wr,
    input  logic              ext_op,
    input  logic              alu_src_a,
    input  logic [1:0]        alu_src_b,
    input  logic [1:0]        alu_op,
    input  logic [1:0]        pc_src,
    input  logic              fill_we,
    input  logic [MEM_AW-1:0] fill_addr,
    input  logic [31:0]       fill_data,
    output logic [31:0]       pc_q,
    output logic [31:0]       ir_q,
    output logic [31:0]       a_q,
    output logic [31:0]       b_q,
    output logic [31:0]       alu_out_q,
    output logic [31:0]       mdr_q,
    output logic              alu_zero
);

    localparam int BYTE_LSB = 2;

    fields_t     fld;
    logic [W-1:0] imm_ext;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W-1:0] alu_res;
    logic [W-1:0] mem_byte_addr;
    logic [W-1:0] mem_rdata;
    logic [W-1:0] rf_a;
    logic [W-1:0] rf_b;
    logic [RIDX_W-1:0] wb_idx;
    logic [W-1:0] wb_val;
    logic [W-1:0] pc_next;
    logic         pc_load;
    logic         unused_addr_bits;

    assign fld     = split_fields(ir_q);
    assign imm_ext = widen_imm(fld.imm, ext_op);

    // Operand selection for the shared ALU
    assign opnd_a = alu_src_a ? a_q : pc_q;

    always_comb begin
        unique case (srcb_e'(alu_src_b))
            SRCB_REG:  opnd_b = b_q;
            SRCB_FOUR: opnd_b = W'(4);
            SRCB_IMM:  opnd_b = imm_ext;
            SRCB_BOFF: opnd_b = {imm_ext[W-3:0], 2'b00};
            default:   opnd_b = b_q;
        endcase
    end

    mdp_alu u_alu (
        .op_a   (opnd_a),
        .op_b   (opnd_b),
        .op     (alu_op_e'(alu_op)),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Shared memory: address from PC (fetch) or ALU result register (data)
    assign mem_byte_addr    = iord ? alu_out_q : pc_q;
    assign unused_addr_bits = ^{mem_byte_addr[BYTE_LSB-1:0],
                                mem_byte_addr[W-1:MEM_AW+BYTE_LSB]};

    mdp_memory #(.AW(MEM_AW)) u_mem (
        .clk       (clk),
        .addr      (mem_byte_addr[MEM_AW+BYTE_LSB-1:BYTE_LSB]),
        .rdata     (mem_rdata),
        .we        (mem_wr),
        .wdata     (b_q),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    // Register file write-back selection
    assign wb_idx = reg_dst ? fld.rd : fld.rt;
    assign wb_val = mem_to_reg ? mdr_q : alu_out_q;

    mdp_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_a (fld.rs),
        .rd_idx_b (fld.rt),
        .rd_val_a (rf_a),
        .rd_val_b (rf_b),
        .wr_en    (reg_wr),
        .wr_idx   (wb_idx),
        .wr_val   (wb_val)
    );

    // Next-PC selection and load condition
    always_comb begin
        unique case (pcsel_e'(pc_src))
            PCSEL_ALU:  pc_next = alu_res;
            PCSEL_HELD: pc_next = alu_out_q;
            PCSEL_JUMP: pc_next = jump_dest(pc_q, fld.tgt);
            PCSEL_RSVD: pc_next = alu_res;
            default:    pc_next = alu_res;
        endcase
    end

    assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

    // Intermediate registers between steps
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            ir_q      <= '0;
            a_q       <= '0;
            b_q       <= '0;
            alu_out_q <= '0;
            mdr_q     <= '0;
        end else begin
            if (pc_load) pc_q <= pc_next;
            if (ir_wr)   ir_q <= mem_rdata;
            a_q       <= rf_a;
            b_q       <= rf_b;
            alu_out_q <= alu_res;
            mdr_q     <= mem_rdata;
        end
    end

endmodule

// File: rtl/mdp_checker.sv
module mdp_checker (
    input logic        clk,
    input logic        rst,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic        ir_wr,
    input logic [1:0]  pc_src,
    input logic        alu_zero,
    input logic [31:0] pc_q,
    input logic [31:0] ir_q,
    input logic [31:0] a_q,
    input logic [31:0] alu_out_q
);

    // R1
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    // R8
    pc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !pc_wr_cond) |=> $stable(pc_q));

    // R8
    pc_untaken_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && pc_wr_cond && !alu_zero) |=> $stable(pc_q));

    // R7
    pc_jump_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'd2) |=>
        (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}));

    // R7
    pc_held_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'd1) |=> (pc_q == $past(alu_out_q)));

    // R5
    zero_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        alu_zero |=> (alu_out_q == 32'd0));

    // R5
    zero_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !alu_zero |=> (alu_out_q != 32'd0));

    // R9
    reg_zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_q[25:21] == 5'd0) |=> (a_q == 32'd0));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_q == 32'd0 && ir_q == 32'd0 && alu_out_q == 32'd0));

endmodule

bind mdp_datapath mdp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .ir_wr      (ir_wr),
    .pc_src     (pc_src),
    .alu_zero   (alu_zero),
    .pc_q       (pc_q),
    .ir_q       (ir_q),
    .a_q        (a_q),
    .alu_out_q  (alu_out_q)
);

// File: tb/tb_mdp_datapath.sv
`timescale 1ns/1ps
module tb_mdp_datapath;

    localparam int AW = 8;
    localparam int MWORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_pc_wr, c_pc_wr_cond, c_iord, c_mem_wr, c_ir_wr, c_reg_dst;
    logic c_mem_to_reg, c_reg_wr, c_ext_op, c_src_a;
    logic [1:0] c_src_b, c_op, c_pc_src;
    logic c_fill_we;
    logic [AW-1:0] c_fill_addr;
    logic [31:0] c_fill_data;
    logic [31:0] pc_q, ir_q, a_q, b_q, alu_out_q, mdr_q;
    logic alu_zero;

    always #4 clk = ~clk;

    mdp_datapath #(.MEM_AW(AW)) dut (
        .clk(clk), .rst(rst), .pc_wr(c_pc_wr), .pc_wr_cond(c_pc_wr_cond),
        .iord(c_iord), .mem_wr(c_mem_wr), .ir_wr(c_ir_wr), .reg_dst(c_reg_dst),
        .mem_to_reg(c_mem_to_reg), .reg_wr(c_reg_wr), .ext_op(c_ext_op),
        .alu_src_a(c_src_a), .alu_src_b(c_src_b), .alu_op(c_op),
        .pc_src(c_pc_src), .fill_we(c_fill_we), .fill_addr(c_fill_addr),
        .fill_data(c_fill_data), .pc_q(pc_q), .ir_q(ir_q), .a_q(a_q),
        .b_q(b_q), .alu_out_q(alu_out_q), .mdr_q(mdr_q), .alu_zero(alu_zero)
    );

    // Behavioural reference state
    logic [31:0] m_mem [MWORDS];
    logic [31:0] m_rf  [32];
    logic [31:0] m_pc, m_ir, m_a, m_b, m_out, m_mdr;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input string sig, input string req, input string scen,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s [%s]: actual %h expected %h", req, sig, scen, act, exp);
        end
    endtask

    task automatic idle();
        c_pc_wr = 0; c_pc_wr_cond = 0; c_iord = 0; c_mem_wr = 0; c_ir_wr = 0;
        c_reg_dst = 0; c_mem_to_reg = 0; c_reg_wr = 0; c_ext_op = 0; c_src_a = 0;
        c_src_b = 0; c_op = 0; c_pc_src = 0; c_fill_we = 0; c_fill_addr = '0;
        c_fill_data = '0;
    endtask

    task automatic compare_regs(input string scen);
        check("pc", "R8", scen, pc_q, m_pc);
        check("ir", "R1", scen, ir_q, m_ir);
        check("a", "R3", scen, a_q, m_a);
        check("b", "R3", scen, b_q, m_b);
        check("alu_out", "R5", scen, alu_out_q, m_out);
        check("mdr", "R10", scen, mdr_q, m_mdr);
    endtask

    // One clock under the currently driven controls; entered just after a negedge.
    task automatic run_cycle(input string scen);
        logic [31:0] imm, ea, eb, res, addr_b, rd_word, wval;
        int rs, rt, rd, widx, mw;
        bit z, load_pc;
        rs = int'(m_ir[25:21]); rt = int'(m_ir[20:16]); rd = int'(m_ir[15:11]);
        imm = c_ext_op ? 32'(signed'(m_ir[15:0])) : {16'h0, m_ir[15:0]};
        ea = c_src_a ? m_a : m_pc;
        case (c_src_b)
            2'd0: eb = m_b;
            2'd1: eb = 32'd4;
            2'd2: eb = imm;
            default: eb = imm * 4;
        endcase
        case (c_op)
            2'd0: res = ea + eb;
            2'd1: res = ea - eb;
            2'd2: res = ea | eb;
            default: res = ea & eb;
        endcase
        z = (res == 0);
        addr_b = c_iord ? m_out : m_pc;
        mw = int'(addr_b[AW+1:2]);
        rd_word = m_mem[mw];
        #1;
        check("alu_zero", "R5", scen, {31'd0, alu_zero}, {31'd0, z});
        @(posedge clk);
        if (c_fill_we) m_mem[c_fill_addr] = c_fill_data;
        else if (c_mem_wr) m_mem[mw] = m_b;
        widx = c_reg_dst ? rd : rt;
        wval = c_mem_to_reg ? m_mdr : m_out;
        load_pc = c_pc_wr || (c_pc_wr_cond && z);
        if (load_pc) begin
            case (c_pc_src)
                2'd1: m_pc = m_out;
                2'd2: m_pc = {m_pc[31:28], m_ir[25:0], 2'b00};
                default: m_pc = res;
            endcase
        end
        if (c_ir_wr) m_ir = rd_word;
        m_a = (rs == 0) ? 32'd0 : m_rf[rs];
        m_b = (rt == 0) ? 32'd0 : m_rf[rt];
        if (c_reg_wr && widx != 0) m_rf[widx] = wval;
        m_out = res;
        m_mdr = rd_word;
        #2;
        compare_regs(scen);
        @(negedge clk);
        idle();
    endtask

    task automatic fetch(input string scen, input logic [1:0] sel);
        c_ir_wr = 1; c_src_b = 2'd1; c_pc_wr = 1; c_pc_src = sel;
        run_cycle(scen);
    endtask
    task automatic decode(input string scen);
        c_src_b = 2'd3; c_ext_op = 1;
        run_cycle(scen);
    endtask
    task automatic exec_rr(input string scen, input logic [1:0] op);
        c_src_a = 1; c_op = op;
        run_cycle(scen);
    endtask
    task automatic exec_ri(input string scen, input logic [1:0] op, input logic sx);
        c_src_a = 1; c_src_b = 2'd2; c_op = op; c_ext_op = sx;
        run_cycle(scen);
    endtask
    task automatic write_back(input string scen, input logic dst, input logic m2r);
        c_reg_wr = 1; c_reg_dst = dst; c_mem_to_reg = m2r;
        run_cycle(scen);
    endtask
    task automatic mem_read(input string scen);
        c_iord = 1;
        run_cycle(scen);
    endtask
    task automatic mem_store(input string scen);
        c_iord = 1; c_mem_wr = 1;
        run_cycle(scen);
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction
    function automatic logic [31:0] enc_i(int rs, int rt, logic [15:0] imm);
        return {6'd13, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] prog [32];
        idle();
        for (int i = 0; i < MWORDS; i++) m_mem[i] = '0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < 32; i++) prog[i] = '0;
        prog[0]  = enc_i(0, 1, 16'h0100);   // r1 = 0x100 (zero-extended)
        prog[1]  = enc_i(0, 2, 16'hFFFF);   // r2 = 0x0000FFFF
        prog[2]  = enc_r(1, 2, 3);          // r3 = r1 + r2
        prog[3]  = enc_i(1, 3, 16'h0004);   // store r3 -> word 65
        prog[4]  = enc_i(1, 4, 16'h0004);   // load r4 <- word 65
        prog[5]  = enc_i(1, 5, 16'hFFFC);   // load r5 <- word 63
        prog[6]  = enc_r(1, 2, 0);          // write aimed at r0
        prog[7]  = enc_i(0, 4, 16'h0005);   // branch r0 == r4 (not taken)
        prog[8]  = enc_i(3, 4, 16'h0002);   // branch r3 == r4 (taken, word 11)
        prog[11] = enc_j(20);
        prog[20] = enc_r(5, 1, 6);          // OR
        prog[21] = enc_r(5, 1, 7);          // SUB
        prog[22] = enc_r(5, 1, 8);          // AND
        prog[23] = enc_i(1, 5, 16'h0004);   // store r5 -> word 65 vs fill
        prog[24] = enc_i(1, 9, 16'h0004);   // load r9 <- word 65
        // Fill program and data while reset is held (R11)
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            c_fill_we = 1; c_fill_addr = AW'(i); c_fill_data = prog[i];
            m_mem[i] = prog[i];
            @(negedge clk);
        end
        c_fill_we = 1; c_fill_addr = AW'(63); c_fill_data = 32'hDEADBEEF;
        m_mem[63] = 32'hDEADBEEF;
        @(negedge clk);
        idle();
        m_pc = 0; m_ir = 0; m_a = 0; m_b = 0; m_out = 0; m_mdr = 0;
        compare_regs("R12 reset state");
        rst = 0;

        // ori r1 / ori r2: zero extension of 0xFFFF (R6)
        fetch("R1 fetch ori", 2'd0); decode("R4 decode");
        exec_ri("R6 zero-extend", 2'd2, 1'b0); write_back("R9 rt write", 0, 0);
        fetch("R2 fetch via PC", 2'd0); decode("R4 branch-offset operand");
        exec_ri("R6 zero-extend FFFF", 2'd2, 1'b0); write_back("R9 rt write", 0, 0);
        // add r3
        fetch("R1 fetch add", 2'd0); decode("R3 operand read");
        exec_rr("R4 reg-reg add", 2'd0); write_back("R9 rd write", 1, 0);
        // store r3
        fetch("R1 fetch store", 2'd0); decode("R3 operand read");
        exec_ri("R6 sign-extend address", 2'd0, 1'b1); mem_store("R10 store");
        // load r4, then load r5 with a negative offset
        fetch("R1 fetch load", 2'd0); decode("R3");
        exec_ri("R6", 2'd0, 1'b1); mem_read("R2 data address");
        write_back("R9 mem data write", 0, 1);
        fetch("R1 fetch load neg", 2'd0); decode("R3");
        exec_ri("R6 sign-extend FFFC", 2'd0, 1'b1); mem_read("R2 data address");
        write_back("R9 mem data write", 0, 1);
        // write aimed at r0 is dropped
        fetch("R1", 2'd0); decode("R3"); exec_rr("R4", 2'd0);
        write_back("R9 r0 write ignored", 1, 0);
        // branch r0 == r4: r0 must still read zero, branch not taken
        fetch("R1", 2'd0); decode("R9 r0 reads zero");
        c_src_a = 1; c_op = 2'd1; c_pc_wr_cond = 1; c_pc_src = 2'd1;
        run_cycle("R8 conditional not taken");
        // branch r3 == r4: taken to word 11
        fetch("R1", 2'd0); decode("R4 target precompute");
        c_src_a = 1; c_op = 2'd1; c_pc_wr_cond = 1; c_pc_src = 2'd1;
        run_cycle("R8 conditional taken");
        check("pc", "R7 branch target", "word 11", pc_q, 32'd44);
        // jump to word 20
        fetch("R1 fetch jump", 2'd0); decode("R3");
        c_pc_wr = 1; c_pc_src = 2'd2;
        run_cycle("R7 jump target");
        check("pc", "R7 jump target", "word 20", pc_q, 32'd80);
        // OR, SUB, AND
        fetch("R1", 2'd0); decode("R3"); exec_rr("R5 OR", 2'd2);
        write_back("R9", 1, 0);
        fetch("R1", 2'd0); decode("R3"); exec_rr("R5 SUB", 2'd1);
        write_back("R9", 1, 0);
        fetch("R1", 2'd0); decode("R3"); exec_rr("R5 AND", 2'd3);
        write_back("R9", 1, 0);
        // store colliding with a fill to the same word: fill wins (R11)
        fetch("R1", 2'd0); decode("R3"); exec_ri("R6", 2'd0, 1'b1);
        c_fill_we = 1; c_fill_addr = AW'(65); c_fill_data = 32'h12345678;
        c_iord = 1; c_mem_wr = 1;
        run_cycle("R11 fill beats store");
        fetch("R1", 2'd0); decode("R3"); exec_ri("R6", 2'd0, 1'b1);
        mem_read("R11 read back fill");
        check("mdr", "R11 fill priority", "word 65", mdr_q, 32'h12345678);
        write_back("R9", 0, 1);
        // reserved next-PC code acts as live ALU result
        fetch("R7 reserved pc_src", 2'd3);
        check("pc", "R7 reserved code", "pc+4", pc_q, 32'd104);
        // idle cycle: nothing loads the PC or IR
        run_cycle("R1 IR hold / R8 PC hold");
        // reset again: state clears, memory survives
        rst = 1;
        @(posedge clk); #2;
        m_pc = 0; m_ir = 0; m_a = 0; m_b = 0; m_out = 0; m_mdr = 0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        compare_regs("R12 reset mid-run");
        @(negedge clk);
        rst = 0;
        fetch("R12 memory kept over reset", 2'd0);
        check("ir", "R12 memory kept", "word 0", ir_q, prog[0]);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule